// File: doc/BRIEF.md
# Selectable Clock Source Divider

This block derives the instruction-rate clock enable for a small processor core from one of four clock sources. A 2-bit mode code picks the source:

- an on-chip oscillator,
- an external square-wave clock,
- an external crystal,
- an external RC network.

Each source has its own divide ratio. The internal 2 MHz oscillator is halved to give a 1 MHz instruction rate. Crystal and RC inputs are divided by four. A square clock passes through undivided, at any rate from DC up to 4 MHz.

Everything runs on one fast sampling clock. The source signals are brought in through two-flop synchronizers, and their rising edges are counted. The block produces a single-cycle enable pulse train rather than a gated clock. In crystal mode it raises an output that turns on the crystal feedback driver. During halt it tells the on-chip oscillator to stop. It also freezes the divider so that counting resumes where it left off.

A change of mode restarts the divider from zero. The first enable after a switch therefore comes only after a full divided period of the new source.

Top module: `clksrc_divider`

## Requirements
- R1: After reset, `core_en` and `xtal_drv_en` are low and the divider count is zero.
- R2: With `mode_sel` = 00 (internal), `core_en` pulses once for every 2 rising edges of `int_osc`.
- R3: With `mode_sel` = 01 (external square), `core_en` pulses once for every rising edge of `ext_clk`.
- R4: With `mode_sel` = 10 (crystal) or 11 (RC), `core_en` pulses once for every 4 rising edges of `ext_clk`.
- R5: `xtal_drv_en` is high exactly when the applied mode is 10. It follows `mode_sel` one sampling cycle later.
- R6: A change of `mode_sel` clears the divider count. No enable is issued until a full divided period of the new source has passed.
- R7: `int_osc_run` is low whenever `halt` is high, and high otherwise.
- R8: While `halt` is high, no `core_en` pulse is produced and source edges are not counted. After `halt` falls, counting resumes from the held count.
- R9: The source that the mode does not select has no effect on `core_en`. In mode 00, `ext_clk` is ignored; in the other modes, `int_osc` is ignored.
- R10: Each `core_en` pulse lasts one sampling cycle, and two pulses are never in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Source code: 00 internal, 01 square, 10 crystal, 11 RC |
| halt | input | 1 | Halt request; stops the oscillator and freezes the divider |
| int_osc | input | 1 | On-chip oscillator output (asynchronous) |
| ext_clk | input | 1 | External clock, crystal or RC input (asynchronous) |
| core_en | output | 1 | Single-cycle instruction clock enable |
| xtal_drv_en | output | 1 | Enables the crystal feedback driver |
| int_osc_run | output | 1 | Run enable for the on-chip oscillator |

## Verification
The hardest cases to reach from the ports are the held count across halt and the cleared count across a mode switch. In both, a partial count is invisible at the outputs. The stimulus leaves the divider partway through a period first: three internal edges before halt, or three crystal edges before switching to RC. It then counts how many further edges are needed before the next pulse appears. That number tells a held or cleared count apart from one that was lost or carried over. Edges applied to the unselected source and during halt are counted as windows that must yield zero pulses.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  localparam int RATIO_W = 3;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_SQR  = 2'b01,
    SRC_XTAL = 2'b10,
    SRC_RC   = 2'b11
  } src_mode_e;

  localparam logic [RATIO_W-1:0] INT_RATIO  = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] SQR_RATIO  = RATIO_W'(1);
  localparam logic [RATIO_W-1:0] XTAL_RATIO = RATIO_W'(4);
  localparam logic [RATIO_W-1:0] RC_RATIO   = RATIO_W'(4);

  function automatic logic [RATIO_W-1:0] ratio_of(input src_mode_e m);
    case (m)
      SRC_INT:  ratio_of = INT_RATIO;
      SRC_SQR:  ratio_of = SQR_RATIO;
      SRC_XTAL: ratio_of = XTAL_RATIO;
      default:  ratio_of = RC_RATIO;
    endcase
  endfunction

  function automatic logic uses_internal(input src_mode_e m);
    uses_internal = (m == SRC_INT);
  endfunction

endpackage

// File: rtl/clksrc_edge_sync.sv
module clksrc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic rise
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], raw};
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R10
  rise_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/clksrc_ratio_cnt.sv
module clksrc_ratio_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             clear,
  input  logic [CNT_W-1:0] ratio,
  output logic             fire,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             fire_q;
  logic             wrap;

  assign wrap = (cnt_q == ratio - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (hold || !tick) begin
      fire_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      fire_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
      fire_q <= 1'b0;
    end
  end

  assign fire  = fire_q;
  assign cnt_o = cnt_q;

  // R6
  clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0) && !fire_q);

  // R8
  hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !clear) |=> $stable(cnt_q) && !fire_q);

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio);

endmodule

// File: rtl/clksrc_divider.sv
module clksrc_divider
  import clksrc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       halt,
  input  logic       int_osc,
  input  logic       ext_clk,
  output logic       core_en,
  output logic       xtal_drv_en,
  output logic       int_osc_run
);
  localparam int NSRC = 2;

  src_mode_e           mode_q;
  logic                mode_chg;
  logic [NSRC-1:0]     raw_src;
  logic [NSRC-1:0]     src_rise;
  logic                sel_rise;
  logic [RATIO_W-1:0]  ratio;
  logic [RATIO_W-1:0]  div_cnt;

  assign raw_src = {ext_clk, int_osc};

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_sync
      clksrc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw_src[i]),
        .rise (src_rise[i])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SRC_INT;
    else        mode_q <= src_mode_e'(mode_sel);
  end

  assign mode_chg = (src_mode_e'(mode_sel) != mode_q);
  assign sel_rise = uses_internal(mode_q) ? src_rise[0] : src_rise[1];
  assign ratio    = ratio_of(mode_q);

  clksrc_ratio_cnt #(.CNT_W(RATIO_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sel_rise),
    .hold (halt),
    .clear(mode_chg),
    .ratio(ratio),
    .fire (core_en),
    .cnt_o(div_cnt)
  );

  assign xtal_drv_en = (mode_q == SRC_XTAL);
  assign int_osc_run = ~halt;

  // R8
  halt_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !core_en);

  // R5
  xtal_follows_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b10) |=> xtal_drv_en);

  // R10
  enable_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> !core_en);

  // R3
  square_every_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == SRC_SQR && !mode_chg && !halt && sel_rise) |=> core_en);

endmodule

// File: tb/sim_clksrc_divider.sv
module sim_clksrc_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       halt = 1'b0;
  logic       int_osc = 1'b0;
  logic       ext_clk = 1'b0;
  logic       core_en, xtal_drv_en, int_osc_run;

  int checks = 0;
  int errors = 0;
  int pulse_cnt = 0;
  int prev_en = 0;
  int exp_q[$];
  string tag_q[$];
  event chk_ev;

  always #2 clk = ~clk;

  clksrc_divider u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .halt(halt),
    .int_osc(int_osc), .ext_clk(ext_clk), .core_en(core_en),
    .xtal_drv_en(xtal_drv_en), .int_osc_run(int_osc_run)
  );

  // monitor: counts pulses, flags adjacent pulses (R10)
  always @(negedge clk) begin
    if (rst_n && core_en) begin
      pulse_cnt++;
      if (prev_en) begin
        checks++; errors++;
        $display("FAIL R10: adjacent pulses actual=1 expected=0");
      end
    end
    prev_en = (rst_n && core_en) ? 1 : 0;
  end

  // scoreboard consumer
  initial forever begin
    @(chk_ev);
    begin
      int e; string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pulse_cnt != e) begin
        errors++;
        $display("FAIL %s: pulses actual=%0d expected=%0d", t, pulse_cnt, e);
      end
    end
  end

  task automatic expect_pulses(input int e, input string t);
    repeat (8) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> chk_ev;
    #1;
    pulse_cnt = 0;
  endtask

  task automatic check_bit(input logic act, input logic e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic edges(input bit use_int, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (use_int) int_osc = 1'b1; else ext_clk = 1'b1;
      repeat (3) @(negedge clk);
      if (use_int) int_osc = 1'b0; else ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_sel = m;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_bit(core_en, 1'b0, "R1 core_en in reset");
    check_bit(xtal_drv_en, 1'b0, "R1 xtal_drv_en in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_bit(xtal_drv_en, 1'b0, "R1 xtal_drv_en after reset");

    // R2: internal halved
    pulse_cnt = 0;
    edges(1, 8);
    expect_pulses(4, "R2 internal 8 edges");
    check_bit(int_osc_run, 1'b1, "R7 oscillator runs when not halted");

    // R9: ext_clk ignored in internal mode
    edges(0, 6);
    expect_pulses(0, "R9 ext_clk ignored in mode 00");

    // R3: square undivided
    set_mode(2'b01);
    pulse_cnt = 0;
    edges(0, 6);
    expect_pulses(6, "R3 square 6 edges");
    edges(1, 5);
    expect_pulses(0, "R9 int_osc ignored in mode 01");
    check_bit(xtal_drv_en, 1'b0, "R5 xtal off in mode 01");

    // R4/R5: crystal
    set_mode(2'b10);
    pulse_cnt = 0;
    check_bit(xtal_drv_en, 1'b1, "R5 xtal on in mode 10");
    edges(0, 8);
    expect_pulses(2, "R4 crystal 8 edges");

    // R6: partial count then switch to RC clears
    edges(0, 3);
    expect_pulses(0, "R6 crystal partial");
    set_mode(2'b11);
    pulse_cnt = 0;
    check_bit(xtal_drv_en, 1'b0, "R5 xtal off in mode 11");
    edges(0, 3);
    expect_pulses(0, "R6 first enable suppressed after switch");
    edges(0, 1);
    expect_pulses(1, "R6 pulse after full period");
    edges(0, 8);
    expect_pulses(2, "R4 RC 8 edges");

    // R8: halt holds count
    set_mode(2'b00);
    pulse_cnt = 0;
    edges(1, 3);
    expect_pulses(1, "R8 pre-halt internal 3 edges");
    @(negedge clk); halt = 1'b1;
    @(negedge clk);
    check_bit(int_osc_run, 1'b0, "R7 oscillator stopped in halt");
    edges(1, 5);
    expect_pulses(0, "R8 no enables during halt");
    @(negedge clk); halt = 1'b0;
    repeat (2) @(negedge clk);
    check_bit(int_osc_run, 1'b1, "R7 oscillator resumes");
    edges(1, 1);
    expect_pulses(1, "R8 held count resumes");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule